// File: doc/BRIEF.md
# Bit-Clock and Frame-Sync Generator

This block produces the serial bit clock and the periodic frame-sync pulse for an audio serial port. A source clock is divided by a programmable 8-bit divisor to form the bit clock. The source is either the block's own clock, with one tick per cycle, or rising edges of an external clock pin that is resynchronised into the clock domain. A frame counter then counts bit clocks. It raises a frame-sync pulse that starts at count zero, lasts a programmable number of bit clocks, and repeats at a programmable frame period of up to 4096 bit clocks.

Two hold inputs control the block. The generator hold stops the divider and latches a fresh configuration. The frame-sync hold keeps only the pulse quiet while the bit clock keeps running. Each output has its own polarity selection. In free-running mode the pulse repeats on its own. In load-triggered mode each load strobe requests a single frame. A stereo frame of two N-bit words uses a period field of 2N-1 and a width field of N-1, for example 31 and 15 for 16-bit words.

Top module: `bitclk_fsync_gen`

## Requirements
- R1: With divisor field D (8 bits), one bit clock lasts D+1 source ticks. Before polarity, the bit clock is high for the first floor(D/2)+1 ticks of each bit period and low for the rest, so with D=0 it stays high.
- R2: The frame sync goes active on the clock edge where a bit period starts at frame count 0. It stays active for W+1 bit clocks, where W is the 8-bit width field.
- R3: A frame lasts P+1 bit clocks, where P is the 12-bit period field. P=4095 gives a 4096-bit-clock frame.
- R4: With source select 0 the divider advances on every clock cycle. With source select 1 it advances only on rising edges of the external clock input, seen after a two-stage synchroniser, so a quiet external pin produces no bit clock.
- R5: With the sync-mode bit at 1 the frame sync repeats at the programmed period with no further stimulus.
- R6: While the generator hold is 1 the bit clock and the frame sync sit at their inactive levels. The first source tick after release starts a bit period, with the bit clock at its active level.
- R7: While the frame-sync hold is 1 the frame sync is inactive and the bit clock keeps running. After release, the frame restarts at count 0 on the first bit period that begins, in step with a bit-clock rise.
- R8: Polarity select 0 gives an active-high output and 1 gives an active-low output, separately for the bit clock and the frame sync. A held generator therefore shows the inverted idle level on each output whose select is 1.
- R9: When the width field is at least the period field, the frame sync stays active through the whole frame. In free-running mode it is then continuously active.
- R10: With the sync-mode bit at 0, the frame sync stays inactive until a load strobe arrives. Each strobe given after the previous frame has ended produces exactly one frame-sync pulse.
- R11: The divisor, width, period, source select, sync mode and both polarities are captured only while the generator hold is 1. Changes to them while the generator runs have no effect.
- R12: The synchronous reset clears the captured configuration, idles the divider and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal divider source |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External divider source, asynchronous |
| gen_hold | input | 1 | 1 holds the divider idle and captures configuration |
| fs_hold | input | 1 | 1 holds the frame sync inactive |
| load_strobe | input | 1 | One-cycle request for a single frame in load-triggered mode |
| cfg_div | input | 8 | Divisor field D |
| cfg_width | input | 8 | Frame-sync width field W |
| cfg_period | input | 12 | Frame period field P |
| cfg_src_ext | input | 1 | 0 internal source, 1 external source |
| cfg_periodic | input | 1 | 1 free-running frame sync, 0 load-triggered |
| cfg_clk_inv | input | 1 | Bit-clock polarity, 1 inverts |
| cfg_fs_inv | input | 1 | Frame-sync polarity, 1 means active low |
| bit_clk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |

## Verification
Releasing the generator hold before a clock edge makes both outputs change at that same edge, so the first sample taken half a cycle later is bit index 0, frame count 0. Sample k is then predicted from (k-1) divided by D+1 and from its remainder. A load strobe or frame-sync release takes effect at the next bit-period start, one edge later when D=0. Checks on those scenarios look for the first active sample and measure run lengths and edge counts, so they do not depend on a guessed absolute cycle. The external-source path adds synchroniser cycles of unknown phase, so its checks measure only the spacing between bit-clock rises, which must be (D+1) external periods.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

    localparam int BFG_DIV_W_DEF  = 8;
    localparam int BFG_WID_W_DEF  = 8;
    localparam int BFG_PER_W_DEF  = 12;
    localparam int BFG_SYNC_DEF   = 2;

    typedef struct packed {
        logic src_ext;
        logic periodic;
        logic clk_inv;
        logic fs_inv;
    } bfg_mode_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } bfg_frame_e;

    function automatic int bfg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfg_cfg_shadow.sv
module bfg_cfg_shadow
    import bfg_pkg::*;
#(
    parameter int DIV_W = BFG_DIV_W_DEF,
    parameter int WID_W = BFG_WID_W_DEF,
    parameter int PER_W = BFG_PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_hold,
    input  logic [DIV_W-1:0] in_div,
    input  logic [WID_W-1:0] in_width,
    input  logic [PER_W-1:0] in_period,
    input  bfg_mode_t        in_mode,
    output logic [DIV_W-1:0] sh_div,
    output logic [WID_W-1:0] sh_width,
    output logic [PER_W-1:0] sh_period,
    output bfg_mode_t        sh_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_div    <= '0;
            sh_width  <= '0;
            sh_period <= '0;
            sh_mode   <= '0;
        end else if (gen_hold) begin
            sh_div    <= in_div;
            sh_width  <= in_width;
            sh_period <= in_period;
            sh_mode   <= in_mode;
        end
    end

    // R11: a running generator never sees its configuration move
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        !gen_hold |=> $stable({sh_div, sh_width, sh_period, sh_mode}));

endmodule

// File: rtl/bfg_src_sel.sv
module bfg_src_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk_i,
    input  logic use_ext,
    output logic src_tick
);

    localparam int HIST = SYNC_STAGES;

    logic [HIST:0] sync_q;
    logic          ext_rise;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_clk_i;
    end

    for (genvar i = 1; i <= HIST; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
        end
    end

    assign ext_rise = sync_q[HIST-1] & ~sync_q[HIST];
    assign src_tick = use_ext ? ext_rise : 1'b1;

    // R4: external ticks are isolated edges, never on back-to-back cycles
    p_ext_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (use_ext && src_tick) |=> (!src_tick || !use_ext));

endmodule

// File: rtl/bfg_divider.sv
module bfg_divider
    import bfg_pkg::*;
#(
    parameter int DIV_W = BFG_DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_hold,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div,
    output logic             bclk_lvl,
    output logic             bit_start
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W-1:0] half;
    logic             at_end;

    assign half   = div >> 1;
    assign at_end = (cnt_q == div);

    always_comb begin
        bit_start = !gen_hold && src_tick && at_end;
        cnt_n     = cnt_q;
        if (src_tick) begin
            cnt_n = at_end ? '0 : cnt_q + ONE;
        end
    end

    // Held count sits at the terminal value so the first tick after
    // release opens a fresh bit period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            bclk_lvl <= 1'b0;
        end else if (gen_hold) begin
            cnt_q    <= div;
            bclk_lvl <= 1'b0;
        end else if (src_tick) begin
            cnt_q    <= cnt_n;
            bclk_lvl <= (cnt_n <= half);
        end
    end

    // R1: the phase count never passes the divisor
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        !gen_hold |-> (cnt_q <= div));

    // R1: every bit period opens with the clock high
    p_start_high_r1: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> bclk_lvl);

    // R6: a held generator parks the bit clock low
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        gen_hold |=> !bclk_lvl);

endmodule

// File: rtl/bfg_frame_ctl.sv
module bfg_frame_ctl
    import bfg_pkg::*;
#(
    parameter int WID_W = BFG_WID_W_DEF,
    parameter int PER_W = BFG_PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_hold,
    input  logic             fs_hold,
    input  logic             periodic,
    input  logic             load_strobe,
    input  logic             bit_start,
    input  logic [WID_W-1:0] width,
    input  logic [PER_W-1:0] period,
    output logic             fs_lvl
);

    localparam int CMP_W = bfg_max(WID_W, PER_W);
    localparam logic [PER_W-1:0] ONE = {{(PER_W-1){1'b0}}, 1'b1};

    bfg_frame_e       st_q, st_n;
    logic [PER_W-1:0] fcnt_q, fcnt_n;
    logic             pend_q, pend_n;
    logic             lvl_n;
    logic             any_hold;
    logic             last_bit;
    logic             start_req;

    assign any_hold  = gen_hold | fs_hold;
    assign last_bit  = (fcnt_q == period);
    assign start_req = periodic | pend_q | load_strobe;

    always_comb begin
        st_n   = st_q;
        fcnt_n = fcnt_q;
        pend_n = pend_q;
        lvl_n  = fs_lvl;
        if (any_hold) begin
            st_n   = FR_IDLE;
            fcnt_n = '0;
            pend_n = 1'b0;
            lvl_n  = 1'b0;
        end else begin
            pend_n = periodic ? 1'b0 : (pend_q | load_strobe);
            if (bit_start) begin
                if (st_q == FR_RUN && !last_bit) begin
                    fcnt_n = fcnt_q + ONE;
                end else if (start_req) begin
                    st_n   = FR_RUN;
                    fcnt_n = '0;
                    pend_n = 1'b0;
                end else begin
                    st_n   = FR_IDLE;
                    fcnt_n = '0;
                end
                lvl_n = (st_n == FR_RUN) && (CMP_W'(fcnt_n) <= CMP_W'(width));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FR_IDLE;
            fcnt_q <= '0;
            pend_q <= 1'b0;
            fs_lvl <= 1'b0;
        end else begin
            st_q   <= st_n;
            fcnt_q <= fcnt_n;
            pend_q <= pend_n;
            fs_lvl <= lvl_n;
        end
    end

    // R7: either hold silences the pulse on the next edge
    p_fs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        any_hold |=> !fs_lvl);

    // R3: the frame position stays inside the programmed period
    p_fcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_RUN) |-> (fcnt_q <= period));

    // R2: the pulse only moves on bit-period starts or holds
    p_fs_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!bit_start && !any_hold) |=> $stable(fs_lvl));

    // R2: a frame starting from idle begins at count zero with the pulse on
    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_IDLE && bit_start && !any_hold && start_req)
        |=> (st_q == FR_RUN && fcnt_q == '0 && fs_lvl));

    // R10: without a request an idle load-triggered frame stays idle
    p_oneshot_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!periodic && st_q == FR_IDLE && !pend_q && !load_strobe) |=> (st_q == FR_IDLE));

endmodule

// File: rtl/bitclk_fsync_gen.sv
module bitclk_fsync_gen
    import bfg_pkg::*;
#(
    parameter int DIV_W       = BFG_DIV_W_DEF,
    parameter int WID_W       = BFG_WID_W_DEF,
    parameter int PER_W       = BFG_PER_W_DEF,
    parameter int SYNC_STAGES = BFG_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk_i,
    input  logic             gen_hold,
    input  logic             fs_hold,
    input  logic             load_strobe,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_src_ext,
    input  logic             cfg_periodic,
    input  logic             cfg_clk_inv,
    input  logic             cfg_fs_inv,
    output logic             bit_clk_o,
    output logic             fsync_o
);

    bfg_mode_t        in_mode;
    bfg_mode_t        sh_mode;
    logic [DIV_W-1:0] sh_div;
    logic [WID_W-1:0] sh_width;
    logic [PER_W-1:0] sh_period;
    logic             src_tick;
    logic             bclk_lvl;
    logic             bit_start;
    logic             fs_lvl;

    always_comb begin
        in_mode.src_ext  = cfg_src_ext;
        in_mode.periodic = cfg_periodic;
        in_mode.clk_inv  = cfg_clk_inv;
        in_mode.fs_inv   = cfg_fs_inv;
    end

    bfg_cfg_shadow #(
        .DIV_W (DIV_W),
        .WID_W (WID_W),
        .PER_W (PER_W)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .gen_hold  (gen_hold),
        .in_div    (cfg_div),
        .in_width  (cfg_width),
        .in_period (cfg_period),
        .in_mode   (in_mode),
        .sh_div    (sh_div),
        .sh_width  (sh_width),
        .sh_period (sh_period),
        .sh_mode   (sh_mode)
    );

    bfg_src_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk       (clk),
        .rst       (rst),
        .ext_clk_i (ext_clk_i),
        .use_ext   (sh_mode.src_ext),
        .src_tick  (src_tick)
    );

    bfg_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .gen_hold  (gen_hold),
        .src_tick  (src_tick),
        .div       (sh_div),
        .bclk_lvl  (bclk_lvl),
        .bit_start (bit_start)
    );

    bfg_frame_ctl #(
        .WID_W (WID_W),
        .PER_W (PER_W)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .gen_hold    (gen_hold),
        .fs_hold     (fs_hold),
        .periodic    (sh_mode.periodic),
        .load_strobe (load_strobe),
        .bit_start   (bit_start),
        .width       (sh_width),
        .period      (sh_period),
        .fs_lvl      (fs_lvl)
    );

    assign bit_clk_o = bclk_lvl ^ sh_mode.clk_inv;
    assign fsync_o   = fs_lvl ^ sh_mode.fs_inv;

    // R12: reset leaves both pins low on the following edge
    p_reset_low_r12: assert property (@(posedge clk)
        rst |=> (!bit_clk_o && !fsync_o));

endmodule

// File: tb/bitclk_fsync_gen_bench.sv
module bitclk_fsync_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_i = 1'b0;
    logic        gen_hold = 1'b1;
    logic        fs_hold = 1'b1;
    logic        load_strobe = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic [7:0]  cfg_width = '0;
    logic [11:0] cfg_period = '0;
    logic        cfg_src_ext = 1'b0;
    logic        cfg_periodic = 1'b1;
    logic        cfg_clk_inv = 1'b0;
    logic        cfg_fs_inv = 1'b0;
    logic        bit_clk_o;
    logic        fsync_o;

    int checks = 0;
    int fails  = 0;
    bit ext_run = 1'b0;
    int ext_ph = 0;

    always #5 clk = ~clk;

    bitclk_fsync_gen u_bitclk_fsync_gen (
        .clk          (clk),
        .rst          (rst),
        .ext_clk_i    (ext_clk_i),
        .gen_hold     (gen_hold),
        .fs_hold      (fs_hold),
        .load_strobe  (load_strobe),
        .cfg_div      (cfg_div),
        .cfg_width    (cfg_width),
        .cfg_period   (cfg_period),
        .cfg_src_ext  (cfg_src_ext),
        .cfg_periodic (cfg_periodic),
        .cfg_clk_inv  (cfg_clk_inv),
        .cfg_fs_inv   (cfg_fs_inv),
        .bit_clk_o    (bit_clk_o),
        .fsync_o      (fsync_o)
    );

    // external source: toggles every 3 clock cycles (period 6)
    always @(negedge clk) begin
        if (ext_run) begin
            ext_ph = ext_ph + 1;
            if (ext_ph == 3) begin
                ext_ph = 0;
                ext_clk_i = ~ext_clk_i;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int d, input int w, input int p, input bit per,
                         input bit ext, input bit ci, input bit fi, input bit fh);
        @(negedge clk);
        gen_hold     = 1'b1;
        fs_hold      = fh;
        load_strobe  = 1'b0;
        cfg_div      = d[7:0];
        cfg_width    = w[7:0];
        cfg_period   = p[11:0];
        cfg_periodic = per;
        cfg_src_ext  = ext;
        cfg_clk_inv  = ci;
        cfg_fs_inv   = fi;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1; gen_hold = 1'b1; fs_hold = 1'b1;
        cfg_clk_inv = 1'b1; cfg_fs_inv = 1'b1;
        repeat (3) @(negedge clk);
        check(bit_clk_o == 1'b0, "R12 bit clock low in reset", int'(bit_clk_o), 0);
        check(fsync_o == 1'b0, "R12 frame sync low in reset", int'(fsync_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(bit_clk_o == 1'b1, "R8 inverted bit clock idles high", int'(bit_clk_o), 1);
        check(fsync_o == 1'b1, "R8 active-low frame sync idles high", int'(fsync_o), 1);
    endtask

    // Sample k after release: bit b=(k-1)/(D+1), phase (k-1)%(D+1)
    task automatic run_trace(input int d, input int w, input int p, input bit ci,
                             input bit fi, input int n, input bit scr, input string tag);
        int  bad;
        int  b;
        int  ph;
        logic eb;
        logic ef;
        bad = 0;
        setup(d, w, p, 1'b1, 1'b0, ci, fi, 1'b0);
        gen_hold = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            b  = (k - 1) / (d + 1);
            ph = (k - 1) % (d + 1);
            eb = ((ph <= d / 2) ? 1'b1 : 1'b0) ^ ci;
            ef = (((b % (p + 1)) <= w) ? 1'b1 : 1'b0) ^ fi;
            if (k == 1)
                check(bit_clk_o == (1'b1 ^ ci), "R6 first period opens active",
                      int'(bit_clk_o), int'(1'b1 ^ ci));
            if (bit_clk_o !== eb || fsync_o !== ef) bad++;
            if (scr && k == 5) begin
                cfg_div = 8'd6; cfg_width = 8'd0; cfg_period = 12'd2;
                cfg_clk_inv = ~ci; cfg_fs_inv = ~fi;
                cfg_periodic = 1'b0; cfg_src_ext = 1'b1;
            end
        end
        check(bad == 0, tag, bad, 0);
        @(negedge clk);
        gen_hold = 1'b1;
    endtask

    task automatic test_gen_hold();
        int bad;
        bad = 0;
        setup(1, 15, 31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        gen_hold = 1'b0;
        repeat (10) @(negedge clk);
        gen_hold = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bit_clk_o !== 1'b0 || fsync_o !== 1'b0) bad++;
            load_strobe = ~load_strobe;
        end
        load_strobe = 1'b0;
        check(bad == 0, "R6 held generator keeps outputs inactive", bad, 0);
    endtask

    task automatic test_fs_hold();
        int   act;
        int   rises;
        int   len;
        bit   found;
        logic prev;
        act = 0; rises = 0; len = 0; found = 1'b0; prev = 1'b0;
        setup(3, 2, 7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        gen_hold = 1'b0;
        for (int k = 0; k < 37; k++) begin
            @(negedge clk);
            if (fsync_o) act++;
            if (bit_clk_o && !prev) rises++;
            prev = bit_clk_o;
        end
        check(act == 0, "R7 frame sync held inactive", act, 0);
        check(rises >= 8, "R7 bit clock runs under frame-sync hold", rises, 9);
        fs_hold = 1'b0;
        for (int k = 0; k < 40 && !found; k++) begin
            @(negedge clk);
            if (fsync_o) begin
                found = 1'b1;
                check(bit_clk_o && !prev, "R7 frame restarts on a bit clock rise",
                      int'(bit_clk_o), 1);
            end
            prev = bit_clk_o;
        end
        check(found, "R7 frame sync resumes after release", int'(found), 1);
        len = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!fsync_o) break;
            len++;
        end
        check(len == 12, "R2 pulse lasts (W+1)*(D+1) cycles", len, 12);
        @(negedge clk);
        gen_hold = 1'b1;
    endtask

    task automatic test_oneshot();
        int   act;
        int   rises;
        logic prev;
        act = 0; rises = 0; prev = 1'b0;
        setup(0, 2, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        gen_hold = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (fsync_o) act++;
        end
        check(act == 0, "R10 no pulse without a load strobe", act, 0);
        act = 0;
        for (int k = 0; k < 45; k++) begin
            @(negedge clk);
            if (fsync_o) act++;
            if (fsync_o && !prev) rises++;
            prev = fsync_o;
            load_strobe = (k == 0 || k == 20);
        end
        load_strobe = 1'b0;
        check(rises == 2, "R10 one pulse per strobe", rises, 2);
        check(act == 6, "R10 each pulse lasts W+1 bit clocks", act, 6);
        @(negedge clk);
        gen_hold = 1'b1;
    endtask

    task automatic test_external();
        int hi;
        int nr;
        int bad;
        int last;
        logic prev;
        hi = 0; nr = 0; bad = 0; last = 0; prev = 1'b0;
        ext_run = 1'b0;
        ext_clk_i = 1'b0;
        setup(1, 1, 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        gen_hold = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (bit_clk_o) hi++;
        end
        check(hi == 0, "R4 quiet external pin gives no bit clock", hi, 0);
        ext_run = 1'b1;
        for (int k = 0; k < 200 && nr < 5; k++) begin
            @(negedge clk);
            if (bit_clk_o && !prev) begin
                if (nr > 0 && (k - last) != 12) bad++;
                last = k;
                nr++;
            end
            prev = bit_clk_o;
        end
        check(nr == 5, "R4 external source drives bit clock", nr, 5);
        check(bad == 0, "R4 bit period equals (D+1) external periods", bad, 0);
        ext_run = 1'b0;
        @(negedge clk);
        gen_hold = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired actual=150000 expected=fewer cycles");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        run_trace(1, 15, 31, 1'b0, 1'b0, 300, 1'b0, "R5 R2 R3 periodic 16-bit stereo frame");
        run_trace(0, 0, 7, 1'b0, 1'b0, 64, 1'b0, "R1 divisor zero");
        run_trace(255, 1, 2, 1'b0, 1'b0, 1600, 1'b0, "R1 maximum divisor");
        run_trace(2, 3, 9, 1'b1, 1'b1, 150, 1'b0, "R8 inverted polarities");
        run_trace(1, 10, 4, 1'b0, 1'b0, 60, 1'b0, "R9 width beyond period");
        run_trace(0, 0, 4095, 1'b0, 1'b0, 8300, 1'b0, "R3 maximum period");
        run_trace(1, 15, 31, 1'b0, 1'b0, 300, 1'b1, "R11 running config changes ignored");
        test_gen_hold();
        test_fs_hold();
        test_oneshot();
        test_external();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule